// File: doc/BRIEF.md
# Fail-Safe Clock Monitor with Switchover

This block watches an external primary clock from a free-running internal RC clock and keeps the system clock alive when the primary stops. The RC clock is divided by a parameter (64 by default) to form a slow sample clock. Each sample rising edge arms a monitor flag, and any falling edge of the primary clears it. If the flag is still armed at the sample falling edge, the primary is declared dead. Primary falling edges are seen in the RC domain through a toggle flop and a synchronizer chain.

On a failure the block moves the clock-select output to the internal oscillator. In the same cycle it sets a sticky interrupt flag and gives the watchdog timer a one-cycle reset pulse. It then stays in a fail-safe state. In that state the primary-running status bit keeps its old value on purpose. Only a reset or a power-managed-mode entry strobe ends the fail-safe state.

After reset the system runs from the internal oscillator until the primary reports ready. The block then selects the primary, sets the status bit and starts monitoring. If the primary never becomes ready, the block stays on the internal clock. All ports are plain control and status pins, because no data stream passes through the block.

Top module: `fscm_top`

## Requirements
- R1: While monitoring, if no primary falling edge arrives in the half sample period after a sample rising edge (DIV/2 RC cycles, DIV = 64), a failure is declared at the sample falling edge. The failure shows within 3*DIV RC cycles after the primary stops.
- R2: A primary clock whose full period is at most DIV/4 RC cycles never causes a failure, a watchdog pulse or a change of clock select.
- R3: On a failure, in the same cycle, `sel_primary` goes to 0, `fail_flag` goes to 1, and `wdt_rst` is high for exactly one RC cycle.
- R4: While in the fail-safe state, `pri_running` keeps the value 1 it had before the failure.
- R5: Restarting the primary clock does not end the fail-safe state. `sel_primary` stays 0 until `pm_entry` or reset. A reset returns all outputs to 0.
- R6: During reset and after it, `sel_primary` and `pri_running` are 0 until `pri_ready` is sampled high. One RC cycle later both are 1.
- R7: If `pri_ready` never rises, `pri_running` stays 0, and a `pm_entry` pulse leaves it at 0.
- R8: With `mon_en` low, a stopped primary causes no failure. Setting `mon_en` high while the primary is stopped then leads to a failure.
- R9: `fail_flag` stays set until a `flag_clr` pulse, and it falls only in the cycle after such a pulse.
- R10: A `pm_entry` pulse in the fail-safe state clears `pri_running`, keeps `sel_primary` at 0, and waits for `pri_ready` again before reselecting the primary.
- R11: No failure is reported while the primary is not yet selected, even if the primary clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Free-running internal RC clock; all state except the toggle flop runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_clk | input | 1 | External primary clock being monitored |
| mon_en | input | 1 | Monitoring enable configuration bit |
| pri_ready | input | 1 | Primary oscillator start-up complete |
| pm_entry | input | 1 | One-cycle strobe: entry to a power-managed mode |
| flag_clr | input | 1 | One-cycle strobe: clear the failure interrupt flag |
| sel_primary | output | 1 | Clock select: 1 = primary, 0 = internal oscillator |
| pri_running | output | 1 | Status bit: primary has been switched in |
| fail_flag | output | 1 | Sticky oscillator-failure interrupt flag |
| wdt_rst | output | 1 | One-cycle watchdog and postscaler reset pulse |

## Verification
The detector is driven with a primary clock whose half period is drawn at random from a fast range, mixed with stretches where the clock is stopped. A silent fast run separates real activity detection from a detector that fires at random. A stopped clock that is caught inside the bound shows that the arm and check timing is correct. Directed cases stop the primary during start-up and with the enable low, which shows whether monitoring is correctly gated. They also restart the primary during fail-safe and apply `pm_entry` and reset, which shows that only the two allowed exits release the fail-safe state.

// File: rtl/fscm_pkg.sv
package fscm_pkg;
  typedef enum logic [1:0] {
    ST_STARTUP  = 2'd0,
    ST_PRIMARY  = 2'd1,
    ST_FAILSAFE = 2'd2
  } fscm_state_e;
endpackage

// File: rtl/fscm_sample_gen.sv
// Divides the RC clock into the sample clock and marks its two edges.
module fscm_sample_gen #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic samp_rise,
  output logic samp_fall
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (cnt == CW'(DIV - 1))        cnt <= '0;
    else                                 cnt <= cnt + 1'b1;
  end

  assign samp_rise = (cnt == '0);
  assign samp_fall = (cnt == CW'(HALF));
endmodule

// File: rtl/fscm_edge_sync.sv
// Turns primary falling edges into one-cycle pulses in the RC domain.
module fscm_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pri_clk,
  output logic pri_edge
);
  logic tgl;
  logic [SYNC_STAGES:0] chain;

  always_ff @(negedge pri_clk or negedge rst_n) begin
    if (!rst_n) tgl <= 1'b0;
    else        tgl <= ~tgl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-1:0], tgl};
  end

  assign pri_edge = chain[SYNC_STAGES] ^ chain[SYNC_STAGES-1];
endmodule

// File: rtl/fscm_detect.sv
// Arm at sample rise, disarm on primary activity, test at sample fall.
module fscm_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic samp_rise,
  input  logic samp_fall,
  input  logic pri_edge,
  output logic fail_det
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed <= 1'b0;
    else if (!active)   armed <= 1'b0;
    else if (samp_rise) armed <= 1'b1;
    else if (pri_edge)  armed <= 1'b0;
  end

  assign fail_det = active && samp_fall && armed && !pri_edge;
endmodule

// File: rtl/fscm_ctrl.sv
// Start-up, primary and fail-safe sequencing with the output flags.
module fscm_ctrl
  import fscm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fail_det,
  input  logic pri_ready,
  input  logic pm_entry,
  input  logic flag_clr,
  output logic monitoring,
  output logic sel_primary,
  output logic pri_running,
  output logic fail_flag,
  output logic wdt_rst
);
  fscm_state_e state, state_nx;
  logic        status_q, status_nx;
  logic        go_fail;

  assign go_fail = (state == ST_PRIMARY) && fail_det;

  always_comb begin
    state_nx  = state;
    status_nx = status_q;
    case (state)
      ST_STARTUP: if (pri_ready) begin
        state_nx  = ST_PRIMARY;
        status_nx = 1'b1;
      end
      ST_PRIMARY: if (fail_det) state_nx = ST_FAILSAFE;
      ST_FAILSAFE: if (pm_entry) begin
        state_nx  = ST_STARTUP;
        status_nx = 1'b0;
      end
      default: begin
        state_nx  = ST_STARTUP;
        status_nx = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_STARTUP;
      status_q  <= 1'b0;
      fail_flag <= 1'b0;
      wdt_rst   <= 1'b0;
    end else begin
      state    <= state_nx;
      status_q <= status_nx;
      wdt_rst  <= go_fail;
      if (go_fail)       fail_flag <= 1'b1;
      else if (flag_clr) fail_flag <= 1'b0;
    end
  end

  assign monitoring  = (state == ST_PRIMARY);
  assign sel_primary = (state == ST_PRIMARY);
  assign pri_running = status_q;
endmodule

// File: rtl/fscm_top.sv
module fscm_top #(
  parameter int DIV         = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic rc_clk,
  input  logic rst_n,
  input  logic pri_clk,
  input  logic mon_en,
  input  logic pri_ready,
  input  logic pm_entry,
  input  logic flag_clr,
  output logic sel_primary,
  output logic pri_running,
  output logic fail_flag,
  output logic wdt_rst
);
  logic samp_rise, samp_fall, pri_edge, fail_det, monitoring;

  fscm_sample_gen #(.DIV(DIV)) u_samp (
    .clk(rc_clk), .rst_n(rst_n), .samp_rise(samp_rise), .samp_fall(samp_fall)
  );

  fscm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(rc_clk), .rst_n(rst_n), .pri_clk(pri_clk), .pri_edge(pri_edge)
  );

  fscm_detect u_det (
    .clk(rc_clk), .rst_n(rst_n), .active(monitoring && mon_en),
    .samp_rise(samp_rise), .samp_fall(samp_fall), .pri_edge(pri_edge),
    .fail_det(fail_det)
  );

  fscm_ctrl u_ctrl (
    .clk(rc_clk), .rst_n(rst_n), .fail_det(fail_det), .pri_ready(pri_ready),
    .pm_entry(pm_entry), .flag_clr(flag_clr), .monitoring(monitoring),
    .sel_primary(sel_primary), .pri_running(pri_running),
    .fail_flag(fail_flag), .wdt_rst(wdt_rst)
  );
endmodule

// File: rtl/fscm_chk.sv
module fscm_chk (
  input logic rc_clk,
  input logic rst_n,
  input logic mon_en,
  input logic pm_entry,
  input logic flag_clr,
  input logic sel_primary,
  input logic pri_running,
  input logic fail_flag,
  input logic wdt_rst
);
  // R3
  wdt_pulse_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);
  // R3
  wdt_flag_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
    wdt_rst |-> fail_flag);
  // R3
  sel_drop_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
    $fell(sel_primary) |-> wdt_rst);
  // R4
  status_hold_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
    $fell(sel_primary) |-> pri_running);
  // R6
  sel_status_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
    sel_primary |-> pri_running);
  // R9
  flag_sticky_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
    $fell(fail_flag) |-> $past(flag_clr));
  // R8
  enable_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> $past(mon_en));
  // R10
  pm_exit_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
    (!sel_primary && pri_running && pm_entry) |=> !pri_running);
endmodule

bind fscm_top fscm_chk u_fscm_chk (
  .rc_clk(rc_clk), .rst_n(rst_n), .mon_en(mon_en), .pm_entry(pm_entry),
  .flag_clr(flag_clr), .sel_primary(sel_primary), .pri_running(pri_running),
  .fail_flag(fail_flag), .wdt_rst(wdt_rst)
);

// File: tb/test_fscm_top.sv
`timescale 1ns/1ps
module test_fscm_top;
  localparam int DIV = 64;

  logic clk = 1'b0;
  logic rst_n, pri_clk, mon_en, pri_ready, pm_entry, flag_clr;
  logic sel_primary, pri_running, fail_flag, wdt_rst;
  int   pri_half = 0;
  int   checks = 0, errors = 0, wdt_cnt = 0;

  always #2.5 clk = ~clk;

  initial pri_clk = 1'b0;
  always begin
    if (pri_half == 0) begin pri_clk = 1'b0; #1; end
    else begin #(pri_half); pri_clk = ~pri_clk; end
  end

  always @(posedge clk) if (rst_n && wdt_rst) wdt_cnt++;

  fscm_top #(.DIV(DIV)) i_fscm_top (
    .rc_clk(clk), .rst_n(rst_n), .pri_clk(pri_clk), .mon_en(mon_en),
    .pri_ready(pri_ready), .pm_entry(pm_entry), .flag_clr(flag_clr),
    .sel_primary(sel_primary), .pri_running(pri_running),
    .fail_flag(fail_flag), .wdt_rst(wdt_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_fail(input int half);
    return half == 0;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_pm();
    pm_entry = 1'b1; cyc(1); pm_entry = 1'b0;
  endtask

  task automatic wait_fail(output int seen);
    seen = 0;
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      if (fail_flag) begin seen = 1; break; end
    end
  endtask

  task automatic enter_primary();
    pri_half = 3; pri_ready = 1'b1; cyc(1);
    chk("R6 sel", sel_primary, 1); chk("R6 status", pri_running, 1);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seen, w0, half;
    void'($urandom(32'h5eed_f5c3));
    rst_n = 0; mon_en = 1; pri_ready = 0; pm_entry = 0; flag_clr = 0;
    cyc(5);
    chk("R6 reset sel", sel_primary, 0); chk("R6 reset status", pri_running, 0);
    chk("R5 reset flag", fail_flag, 0); chk("R3 reset wdt", wdt_rst, 0);
    rst_n = 1;
    pri_half = 4; cyc(300);
    chk("R7 no ready sel", sel_primary, 0); chk("R7 no ready status", pri_running, 0);
    pulse_pm(); cyc(1);
    chk("R7 pm status", pri_running, 0);
    pri_half = 0; cyc(4 * DIV);
    chk("R11 startup stop flag", fail_flag, 0); chk("R11 startup wdt", wdt_cnt, 0);
    enter_primary();

    // random mix of fast runs and stopped primary
    for (int it = 0; it < 16; it++) begin
      half = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 40);
      w0 = wdt_cnt;
      pri_half = half;
      if (exp_fail(half)) begin
        wait_fail(seen);
        chk("R1 detect", seen, 1);
        cyc(2);
        chk("R3 sel", sel_primary, 0); chk("R3 wdt count", wdt_cnt - w0, 1);
        chk("R4 status", pri_running, 1);
        pri_half = 5; cyc(3 * DIV);
        chk("R5 stay failsafe", sel_primary, 0);
        chk("R9 sticky", fail_flag, 1);
        flag_clr = 1; cyc(1); flag_clr = 0;
        chk("R9 cleared", fail_flag, 0);
        pri_ready = 0; pulse_pm(); cyc(1);
        chk("R10 status", pri_running, 0); chk("R10 sel", sel_primary, 0);
        cyc(DIV);
        chk("R10 wait ready", sel_primary, 0);
        enter_primary();
      end else begin
        cyc(4 * DIV);
        chk("R2 no flag", fail_flag, 0); chk("R2 no wdt", wdt_cnt - w0, 0);
        chk("R2 sel", sel_primary, 1);
      end
    end

    // monitoring disabled
    mon_en = 0; pri_half = 0; cyc(5 * DIV);
    chk("R8 disabled flag", fail_flag, 0); chk("R8 disabled sel", sel_primary, 1);
    mon_en = 1; wait_fail(seen);
    chk("R8 enabled detect", seen, 1);
    cyc(2);
    chk("R4 status after enable", pri_running, 1);

    // reset leaves fail-safe
    rst_n = 0; cyc(2);
    chk("R5 reset sel", sel_primary, 0); chk("R5 reset flag", fail_flag, 0);
    chk("R5 reset status", pri_running, 0);
    rst_n = 1; cyc(1);
    enter_primary();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule